// File: doc/BRIEF.md
# Condition Flag Register Update

This block holds the five status flags of a small 8-bit datapath: an interrupt mask flag and the four arithmetic flags negative, zero, overflow and carry. When its load enable is high at a rising clock edge, each flag picks its next value on its own. The choices are the matching bit of the ALU flag vector, the matching bit of the data bus, a fixed value, or its current value. The control sequencer drives one 2-bit source select per flag. Instructions can therefore restore the whole register from the bus, take arithmetic results, or clear or set single flags, all in the same load.

The interrupt flag reads its select differently from the arithmetic flags. For the interrupt flag, code 00 clears and code 10 sets. For the arithmetic flags, code 00 takes the ALU result and code 10 clears. The ALU flags and the bus value come from outside and are taken as stable before the clock edge. The stored value is given out as a 5-bit vector and as an 8-bit readback word.

Top module: `ccr_update`

## Requirements
- R1: A synchronous active-low reset clears all five flags at the next rising edge, and it wins over an asserted load enable.
- R2: While the load enable is low, no flag changes, whatever values the selects, the bus and the ALU flags have.
- R3: With load enabled, an arithmetic flag whose select is 00 takes its ALU flag bit (alu_flags_i bit 3 = N, 2 = Z, 1 = V, 0 = C).
- R4: With load enabled, an arithmetic flag whose select is 01 takes the bus bit at its own position (bus bit 3 for N, 2 for Z, 1 for V, 0 for C).
- R5: With load enabled, an arithmetic flag whose select is 10 becomes 0.
- R6: With load enabled, an arithmetic flag whose select is 11 keeps its value.
- R7: With load enabled, the interrupt flag becomes 0 for select 00 and 1 for select 10.
- R8: With load enabled, the interrupt flag takes bus bit 4 for select 01 and keeps its value for select 11.
- R9: flags_q_o holds I, N, Z, V, C at bits 4, 3, 2, 1, 0. flags_rd_o equals that value zero-extended to 8 bits, so bits 7:5 always read 0.
- R10: Each flag follows only its own select within a load, so any mix of the five selects gives the per-flag results of R3 to R8 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_en_i | input | 1 | Allows the flags to update at this edge |
| alu_flags_i | input | 4 | ALU result flags N, Z, V, C at bits 3..0 |
| bus_i | input | 8 | Data bus value; bits 4..0 feed the flags |
| sel_c_i | input | 2 | Carry flag source select |
| sel_v_i | input | 2 | Overflow flag source select |
| sel_z_i | input | 2 | Zero flag source select |
| sel_n_i | input | 2 | Negative flag source select |
| sel_i_i | input | 2 | Interrupt flag source select |
| flags_q_o | output | 5 | Stored flags I, N, Z, V, C at bits 4..0 |
| flags_rd_o | output | 8 | Stored flags zero-extended to 8 bits |

## Verification
Two events can meet in one cycle. The first is a reset with the load enable high and selects that would set or load flags. The bench drives that on purpose, both at start-up and in the middle of the run after the flags have been set, and it expects all zeros, not the loaded value. The second is five different updates in one load, for example I being set while C clears, Z takes the bus and N holds. Random select mixes provoke it. A per-flag model scores each flag against its own rule and compares the whole vector one edge later.

// File: rtl/ccr_pkg.sv
// Package: shared widths, flag bit positions and select encodings for
// the condition flag register. Assumes exactly five flags, one of them
// an interrupt mask at the top position.
package ccr_pkg;
    localparam int FLAG_W  = 5;
    localparam int ARITH_N = 4;
    localparam int SEL_W   = 2;

    localparam int POS_C = 0;
    localparam int POS_V = 1;
    localparam int POS_Z = 2;
    localparam int POS_N = 3;
    localparam int POS_I = 4;

    typedef enum logic [SEL_W-1:0] {
        ASRC_ALU  = 2'b00,
        ASRC_BUS  = 2'b01,
        ASRC_ZERO = 2'b10,
        ASRC_HOLD = 2'b11
    } arith_src_e;

    typedef enum logic [SEL_W-1:0] {
        ISRC_ZERO = 2'b00,
        ISRC_BUS  = 2'b01,
        ISRC_ONE  = 2'b10,
        ISRC_HOLD = 2'b11
    } irq_src_e;
endpackage

// File: rtl/ccr_arith_cell.sv
// Next-value selector for one arithmetic flag (N, Z, V or C).
// Purely combinational. Assumes the caller gates the result with the
// register load enable.
module ccr_arith_cell
    import ccr_pkg::*;
(
    input  logic             cur_i,
    input  logic             alu_bit_i,
    input  logic             bus_bit_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             nxt_o
);
    // pick the flag source named by the select
    always_comb begin
        unique case (arith_src_e'(sel_i))
            ASRC_ALU:  nxt_o = alu_bit_i;
            ASRC_BUS:  nxt_o = bus_bit_i;
            ASRC_ZERO: nxt_o = 1'b0;
            default:   nxt_o = cur_i;
        endcase
    end
endmodule

// File: rtl/ccr_irq_cell.sv
// Next-value selector for the interrupt mask flag. It uses its own code
// meanings: clear, load from bus, set, hold. Combinational; the caller
// gates it with the load enable.
module ccr_irq_cell
    import ccr_pkg::*;
(
    input  logic             cur_i,
    input  logic             bus_bit_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             nxt_o
);
    // pick the interrupt flag source named by the select
    always_comb begin
        unique case (irq_src_e'(sel_i))
            ISRC_ZERO: nxt_o = 1'b0;
            ISRC_BUS:  nxt_o = bus_bit_i;
            ISRC_ONE:  nxt_o = 1'b1;
            default:   nxt_o = cur_i;
        endcase
    end
endmodule

// File: rtl/ccr_state_reg.sv
// Flag storage: a W-bit register with a synchronous active-low clear
// that wins over the load. Assumes d_i is settled before the edge.
module ccr_state_reg #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    // clear on reset, otherwise capture when loading
    always_ff @(posedge clk) begin
        if (!rst_n)      q_o <= '0;
        else if (load_i) q_o <= d_i;
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk) !rst_n |=> q_o == '0);

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(q_o));
endmodule

// File: rtl/ccr_update.sv
// Top of the condition flag register. Each flag gets its own next-value
// cell; the register captures all five at once when load_en_i is high.
// Assumes the ALU flags and the bus are stable before the rising edge.
module ccr_update
    import ccr_pkg::*;
#(
    parameter int BUS_W = 8,
    parameter int RD_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en_i,
    input  logic [ARITH_N-1:0] alu_flags_i,
    input  logic [BUS_W-1:0]  bus_i,
    input  logic [SEL_W-1:0]  sel_c_i,
    input  logic [SEL_W-1:0]  sel_v_i,
    input  logic [SEL_W-1:0]  sel_z_i,
    input  logic [SEL_W-1:0]  sel_n_i,
    input  logic [SEL_W-1:0]  sel_i_i,
    output logic [FLAG_W-1:0] flags_q_o,
    output logic [RD_W-1:0]   flags_rd_o
);
    localparam int PAD_W = RD_W - FLAG_W;

    logic [SEL_W-1:0]  arith_sel [ARITH_N];
    logic [FLAG_W-1:0] flags_nxt;
    logic              unused_bus_hi;

    // gather the per-flag selects by bit position
    always_comb begin
        arith_sel[POS_C] = sel_c_i;
        arith_sel[POS_V] = sel_v_i;
        arith_sel[POS_Z] = sel_z_i;
        arith_sel[POS_N] = sel_n_i;
    end

    assign unused_bus_hi = ^bus_i[BUS_W-1:FLAG_W];

    genvar g;
    generate
        for (g = 0; g < ARITH_N; g++) begin : g_arith
            ccr_arith_cell u_cell (
                .cur_i     (flags_q_o[g]),
                .alu_bit_i (alu_flags_i[g]),
                .bus_bit_i (bus_i[g]),
                .sel_i     (arith_sel[g]),
                .nxt_o     (flags_nxt[g])
            );
        end
    endgenerate

    ccr_irq_cell u_irq (
        .cur_i     (flags_q_o[POS_I]),
        .bus_bit_i (bus_i[POS_I]),
        .sel_i     (sel_i_i),
        .nxt_o     (flags_nxt[POS_I])
    );

    ccr_state_reg #(.W(FLAG_W)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_en_i),
        .d_i    (flags_nxt),
        .q_o    (flags_q_o)
    );

    assign flags_rd_o = {{PAD_W{1'b0}}, flags_q_o};

    // R3
    c_from_alu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en_i && sel_c_i == 2'b00 |=> flags_q_o[POS_C] == $past(alu_flags_i[POS_C]));

    // R4
    z_from_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en_i && sel_z_i == 2'b01 |=> flags_q_o[POS_Z] == $past(bus_i[POS_Z]));

    // R5
    v_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en_i && sel_v_i == 2'b10 |=> !flags_q_o[POS_V]);

    // R6
    n_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en_i && sel_n_i == 2'b11 |=> $stable(flags_q_o[POS_N]));

    // R7
    i_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en_i && sel_i_i == 2'b10 |=> flags_q_o[POS_I]);

    // R7
    i_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en_i && sel_i_i == 2'b00 |=> !flags_q_o[POS_I]);

    // R8
    i_from_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en_i && sel_i_i == 2'b01 |=> flags_q_o[POS_I] == $past(bus_i[POS_I]));
endmodule

// File: tb/sim_ccr_update.sv
`timescale 1ns/1ps
module sim_ccr_update;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_en = 1'b0;
    logic [3:0] alu = '0;
    logic [7:0] bus = '0;
    logic [1:0] sc = '0, sv = '0, sz = '0, sn = '0, si = '0;
    logic [4:0] fq;
    logic [7:0] frd;

    int checks = 0;
    int errors = 0;

    logic [4:0] model = '0;
    logic [4:0] exp_q [$];
    string      tag_q [$];

    always #2.5 clk = ~clk;

    ccr_update u0 (
        .clk(clk), .rst_n(rst_n), .load_en_i(load_en), .alu_flags_i(alu),
        .bus_i(bus), .sel_c_i(sc), .sel_v_i(sv), .sel_z_i(sz),
        .sel_n_i(sn), .sel_i_i(si), .flags_q_o(fq), .flags_rd_o(frd)
    );

    // arithmetic flag rule: 00 alu, 01 bus, 10 zero, 11 keep
    function automatic logic arith_rule(logic cur, logic a, logic b, logic [1:0] s);
        case (s)
            2'b00:   return a;
            2'b01:   return b;
            2'b10:   return 1'b0;
            default: return cur;
        endcase
    endfunction

    // interrupt flag rule: 00 zero, 01 bus, 10 one, 11 keep
    function automatic logic irq_rule(logic cur, logic b, logic [1:0] s);
        case (s)
            2'b00:   return 1'b0;
            2'b01:   return b;
            2'b10:   return 1'b1;
            default: return cur;
        endcase
    endfunction

    // driver: apply one cycle of stimulus and queue the expected flags
    task automatic step(string tag, logic r, logic ld, logic [3:0] a, logic [7:0] b,
                        logic [1:0] c_s, logic [1:0] v_s, logic [1:0] z_s,
                        logic [1:0] n_s, logic [1:0] i_s);
        logic [4:0] nx;
        @(negedge clk);
        rst_n = r; load_en = ld; alu = a; bus = b;
        sc = c_s; sv = v_s; sz = z_s; sn = n_s; si = i_s;
        if (!r) nx = '0;
        else if (!ld) nx = model;
        else begin
            nx[0] = arith_rule(model[0], a[0], b[0], c_s);
            nx[1] = arith_rule(model[1], a[1], b[1], v_s);
            nx[2] = arith_rule(model[2], a[2], b[2], z_s);
            nx[3] = arith_rule(model[3], a[3], b[3], n_s);
            nx[4] = irq_rule(model[4], b[4], i_s);
        end
        model = nx;
        exp_q.push_back(nx);
        tag_q.push_back(tag);
    endtask

    // monitor: compare each queued item just after the edge that makes it
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [4:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (fq !== e) begin
                    errors++;
                    $display("FAIL %s flags actual=%b expected=%b", t, fq, e);
                end
                checks++;
                if (frd !== {3'b000, e}) begin
                    errors++;
                    $display("FAIL R9 readback actual=%h expected=%h", frd, {3'b000, e});
                end
            end
        end
    end

    // watchdog: a hung run counts as a failure
    initial begin
        #900000;
        errors++;
        $display("FAIL R2 watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset with load high and set-type selects still gives zero
        step("R1", 1'b0, 1'b1, 4'hF, 8'hFF, 2'b01, 2'b01, 2'b01, 2'b01, 2'b10);
        step("R1", 1'b0, 1'b0, 4'h0, 8'h00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
        // R4 / R8: load every flag from the bus
        step("R4", 1'b1, 1'b1, 4'h0, 8'b1110_1010, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01);
        step("R8", 1'b1, 1'b1, 4'h0, 8'b0001_0101, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01);
        // R3: all arithmetic flags from the ALU, I kept
        step("R3", 1'b1, 1'b1, 4'b1010, 8'h00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11);
        step("R3", 1'b1, 1'b1, 4'b0101, 8'hFF, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11);
        // R7: set I while others hold (R6)
        step("R7", 1'b1, 1'b1, 4'h0, 8'h00, 2'b11, 2'b11, 2'b11, 2'b11, 2'b10);
        step("R6", 1'b1, 1'b1, 4'hA, 8'hAA, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11);
        // R5: clear arithmetic flags after setting them from the bus
        step("R4", 1'b1, 1'b1, 4'h0, 8'h0F, 2'b01, 2'b01, 2'b01, 2'b01, 2'b11);
        step("R5", 1'b1, 1'b1, 4'hF, 8'hFF, 2'b10, 2'b10, 2'b10, 2'b10, 2'b11);
        // R7: clear I
        step("R7", 1'b1, 1'b1, 4'hF, 8'hFF, 2'b11, 2'b11, 2'b11, 2'b11, 2'b00);
        // R2: load low, busy inputs, nothing moves
        step("R4", 1'b1, 1'b1, 4'h0, 8'h1F, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01);
        for (int k = 0; k < 20; k++)
            step("R2", 1'b1, 1'b0, 4'($urandom), 8'($urandom), 2'($urandom),
                 2'($urandom), 2'($urandom), 2'($urandom), 2'($urandom));
        // R10: mixed selects in one load
        step("R10", 1'b1, 1'b1, 4'b0100, 8'b0000_0000, 2'b10, 2'b00, 2'b01, 2'b11, 2'b10);
        for (int k = 0; k < 400; k++)
            step("R10", 1'b1, 1'b1, 4'($urandom), 8'($urandom), 2'($urandom),
                 2'($urandom), 2'($urandom), 2'($urandom), 2'($urandom));
        // R1: reset in mid-run after setting everything
        step("R4", 1'b1, 1'b1, 4'h0, 8'hFF, 2'b01, 2'b01, 2'b01, 2'b01, 2'b10);
        step("R1", 1'b0, 1'b1, 4'hF, 8'hFF, 2'b00, 2'b01, 2'b11, 2'b11, 2'b11);
        for (int k = 0; k < 100; k++)
            step("R10", 1'b1, 1'($urandom), 4'($urandom), 8'($urandom), 2'($urandom),
                 2'($urandom), 2'($urandom), 2'($urandom), 2'($urandom));
        repeat (4) @(posedge clk);
        #2;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule